// File: doc/BRIEF.md
# Single-Wire Bus Master Engine

This block is a hardware master for a bus that uses one open-drain wire with an external pull-up. It runs the bus reset with presence detection, single write and read time slots, and byte transfers made of eight slots in a row. A controller picks an operation with a three-bit code, supplies a data byte and pulses a start strobe. It then waits for a one-clock done pulse. After that pulse it reads the received byte or the presence flag.

Every operation follows one fixed pattern: an optional pre-wait, a low phase, a release phase and, for reads and bus resets, a sample point and a recovery phase. Ten durations set the length of each phase. Two tables of these durations are built in, one for standard speed and one for overdrive. A speed input selects the table. All durations are counted in microsecond ticks, and an internal divider derives the tick from the system clock. The pad side is a pull-low enable plus a line input. The line input passes through a two-flop synchroniser.

Top module: `ow_master`

## Requirements
- R1: After reset the block is idle: busy, done and bus_pull are 0, rd_byte is 0, presence is 0, and standard timing is selected.
- R2: A bus reset (op_code 0) waits the pre-wait, pulls the line low for 480 µs at standard speed, releases it, and samples the line 70 µs later. It then waits a further 410 µs and finishes, so the operation is 960 µs in total. presence is the inverse of the sampled level. The standard pre-wait is zero and adds no time.
- R3: A bit write (op_code 1) sends wr_byte bit 0. At standard speed a 1 is low for 6 µs and released for 64 µs. A 0 is low for 60 µs and released for 10 µs.
- R4: A bit read (op_code 2) pulls low for 6 µs, releases, samples 9 µs later and recovers for 55 µs (70 µs in total). The sampled bit appears in rd_byte bit 0, and the upper bits are 0.
- R5: A byte write (op_code 3) sends eight write slots back to back, least significant bit first.
- R6: A byte read (op_code 4) runs eight read slots. The first received bit ends up in rd_byte bit 0 and the last in bit 7.
- R7: When speed_od is 1, the overdrive durations apply. Write 1 is 1 µs low plus 7 µs released. Write 0 is 7 µs low plus 2 µs released. A read slot is 1, 1 and 7 µs. A bus reset is a 2 µs pre-wait, 70 µs low, a 8 µs wait to the sample point and 40 µs of recovery.
- R8: speed_od is taken only while idle, including the cycle in which start is accepted. A change during an operation has no effect on that operation.
- R9: A start pulse while busy is ignored. The running operation keeps its length, and no extra operation follows.
- R10: done is high for exactly one clock per operation. rd_byte and presence change only in that clock: rd_byte on reads and presence on bus resets.
- R11: bus_pull is high only during the low phases of an operation. The line is never driven high, and it is released whenever the block is idle.
- R12: Start with an unused op_code (5 to 7) is ignored: busy stays 0 and the line is not pulled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-clock strobe that launches an operation when idle |
| op_code | input | 3 | 0 bus reset, 1 write bit, 2 read bit, 3 write byte, 4 read byte |
| wr_byte | input | BYTE_W | Data to send (bit 0 only for a bit write) |
| speed_od | input | 1 | 1 selects overdrive timing, 0 standard |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-clock pulse at the end of an operation |
| presence | output | 1 | Result of the last bus reset (1 = a device answered) |
| rd_byte | output | BYTE_W | Result of the last read |
| bus_pull | output | 1 | Pad enable that pulls the line low |
| bus_in | input | 1 | Level seen on the line |

## Verification
There are two coincidences to check. The first is the done pulse of one operation landing in the same clock as the start of the next. The bench raises start in the very clock where it sees done, then requires the second slot to run at its full length with its own low width, and requires two done pulses. The second is a speed change landing in the same clock as an accepted start. The bench changes speed_od together with start and requires the new table to apply. It also changes speed_od one clock after start and requires the old table to stay in force. A stray start during a slot is judged by the unchanged busy length and by the number of low pulses.

// File: rtl/ow_pkg.sv
package ow_pkg;

    typedef enum logic [2:0] {
        OP_BUS_RESET = 3'd0,
        OP_WR_BIT    = 3'd1,
        OP_RD_BIT    = 3'd2,
        OP_WR_BYTE   = 3'd3,
        OP_RD_BYTE   = 3'd4
    } op_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_PRE,
        PH_LOW,
        PH_REL,
        PH_TAIL
    } phase_e;

    // phase durations in microsecond ticks
    typedef struct packed {
        logic [15:0] lo_one;     // low time, write 1 and read slots
        logic [15:0] rel_one;    // release time after a written 1
        logic [15:0] lo_zero;    // low time, write 0
        logic [15:0] rel_zero;   // release time after a written 0
        logic [15:0] smp_wait;   // release to sample, read slot
        logic [15:0] rd_tail;    // recovery after a read sample
        logic [15:0] pre_wait;   // delay ahead of a bus reset
        logic [15:0] rst_low;    // bus reset low time
        logic [15:0] pres_wait;  // release to presence sample
        logic [15:0] rst_tail;   // recovery after presence sample
    } slot_tmg_t;

    localparam slot_tmg_t TMG_STD = '{
        lo_one: 16'd6, rel_one: 16'd64, lo_zero: 16'd60, rel_zero: 16'd10,
        smp_wait: 16'd9, rd_tail: 16'd55, pre_wait: 16'd0,
        rst_low: 16'd480, pres_wait: 16'd70, rst_tail: 16'd410
    };

    // overdrive: fractional ideal values floored to whole microseconds
    localparam slot_tmg_t TMG_OD = '{
        lo_one: 16'd1, rel_one: 16'd7, lo_zero: 16'd7, rel_zero: 16'd2,
        smp_wait: 16'd1, rd_tail: 16'd7, pre_wait: 16'd2,
        rst_low: 16'd70, pres_wait: 16'd8, rst_tail: 16'd40
    };

    function automatic slot_tmg_t pick_tmg(input logic od);
        return od ? TMG_OD : TMG_STD;
    endfunction

    function automatic logic op_known(input logic [2:0] code);
        return code <= 3'd4;
    endfunction

endpackage

// File: rtl/ow_tick_gen.sv
module ow_tick_gen #(
    parameter int CLKS_PER_US = 250
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int DIV_W = (CLKS_PER_US > 1) ? $clog2(CLKS_PER_US) : 1;
    localparam logic [DIV_W-1:0] LAST = DIV_W'(CLKS_PER_US - 1);

    logic [DIV_W-1:0] div_q;

    // held at zero while idle so the first tick lands a full period after start
    always_ff @(posedge clk) begin
        if (rst || !run)       div_q <= '0;
        else if (div_q == LAST) div_q <= '0;
        else                   div_q <= div_q + 1'b1;
    end

    assign tick = run && (div_q == LAST);
endmodule

// File: rtl/ow_sync.sv
module ow_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    // idle line rests high through the pull-up
    always_ff @(posedge clk) begin
        if (rst) chain_q <= '1;
        else     chain_q <= {chain_q[STAGES-2:0], d};
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/ow_slot_seq.sv
module ow_slot_seq
    import ow_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [2:0]        op_code,
    input  logic [BYTE_W-1:0] wr_byte,
    input  slot_tmg_t         tmg,
    input  logic              tick,
    input  logic              line_s,
    output logic              busy,
    output logic              done,
    output logic              presence,
    output logic [BYTE_W-1:0] rd_byte,
    output logic              line_oe
);
    localparam int CNT_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    phase_e            ph_q;
    op_e               op_q;
    logic [BYTE_W-1:0] sh_q;
    logic [CNT_W-1:0]  bit_q;
    logic [15:0]       tcnt_q;
    logic              smp_q;

    logic        is_rst, is_wr, is_byte, expire;
    logic [15:0] dur;

    assign is_rst  = (op_q == OP_BUS_RESET);
    assign is_wr   = (op_q == OP_WR_BIT) || (op_q == OP_WR_BYTE);
    assign is_byte = (op_q == OP_WR_BYTE) || (op_q == OP_RD_BYTE);

    always_comb begin
        unique case (ph_q)
            PH_PRE:  dur = tmg.pre_wait;
            PH_LOW:  dur = is_rst ? tmg.rst_low :
                           (is_wr && !sh_q[0]) ? tmg.lo_zero : tmg.lo_one;
            PH_REL:  dur = is_rst ? tmg.pres_wait :
                           !is_wr ? tmg.smp_wait :
                           sh_q[0] ? tmg.rel_one : tmg.rel_zero;
            PH_TAIL: dur = is_rst ? tmg.rst_tail : tmg.rd_tail;
            default: dur = 16'd0;
        endcase
    end

    assign expire = (dur == 16'd0) || (tick && (tcnt_q == dur - 16'd1));

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q     <= PH_IDLE;
            op_q     <= OP_BUS_RESET;
            sh_q     <= '0;
            bit_q    <= '0;
            tcnt_q   <= '0;
            smp_q    <= 1'b1;
            done     <= 1'b0;
            presence <= 1'b0;
            rd_byte  <= '0;
        end else begin
            done <= 1'b0;
            if (ph_q == PH_IDLE) begin
                if (start && op_known(op_code)) begin
                    op_q   <= op_e'(op_code);
                    sh_q   <= wr_byte;
                    bit_q  <= '0;
                    tcnt_q <= '0;
                    // a zero pre-wait costs no cycle at all
                    ph_q   <= (op_e'(op_code) == OP_BUS_RESET && tmg.pre_wait != 16'd0)
                              ? PH_PRE : PH_LOW;
                end
            end else if (!expire) begin
                tcnt_q <= tcnt_q + {15'd0, tick};
            end else begin
                tcnt_q <= '0;
                unique case (ph_q)
                    PH_PRE: ph_q <= PH_LOW;
                    PH_LOW: ph_q <= PH_REL;
                    PH_REL: begin
                        if (is_wr) begin
                            sh_q <= sh_q >> 1;
                        end else if (is_rst) begin
                            smp_q <= line_s;
                        end else begin
                            sh_q <= {line_s, sh_q[BYTE_W-1:1]};
                        end
                        if (!is_wr) ph_q <= PH_TAIL;
                    end
                    default: ;
                endcase
                // end of a slot: write after release, others after recovery
                if ((ph_q == PH_REL && is_wr) || ph_q == PH_TAIL) begin
                    if (is_byte && bit_q != LAST_BIT) begin
                        bit_q <= bit_q + 1'b1;
                        ph_q  <= PH_LOW;
                    end else begin
                        ph_q <= PH_IDLE;
                        done <= 1'b1;
                        if (is_rst)
                            presence <= ~smp_q;
                        else if (op_q == OP_RD_BIT)
                            rd_byte <= {{(BYTE_W-1){1'b0}}, sh_q[BYTE_W-1]};
                        else if (op_q == OP_RD_BYTE)
                            rd_byte <= sh_q;
                    end
                end
            end
        end
    end

    assign busy    = (ph_q != PH_IDLE);
    assign line_oe = (ph_q == PH_LOW);

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R10
    AST_DONE_AFTER_WORK: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(busy) && !busy); // R10
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(rd_byte)); // R10
    AST_PRES_HOLD: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(presence)); // R2
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> $stable(op_q)); // R9
    AST_PULL_IN_OP: assert property (@(posedge clk) disable iff (rst)
        $rose(line_oe) |-> $past(busy) || $past(start)); // R11
endmodule

// File: rtl/ow_master.sv
module ow_master
    import ow_pkg::*;
#(
    parameter int CLKS_PER_US = 250,
    parameter int BYTE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [2:0]        op_code,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic              speed_od,
    output logic              busy,
    output logic              done,
    output logic              presence,
    output logic [BYTE_W-1:0] rd_byte,
    output logic              bus_pull,
    input  logic              bus_in
);
    logic      spd_q;
    logic      tick;
    logic      line_s;
    slot_tmg_t tmg;

    // speed is frozen for the length of an operation
    always_ff @(posedge clk) begin
        if (rst)        spd_q <= 1'b0;
        else if (!busy) spd_q <= speed_od;
    end

    // at the start edge the live input decides the first phase
    assign tmg = pick_tmg(busy ? spd_q : speed_od);

    ow_tick_gen #(.CLKS_PER_US(CLKS_PER_US)) tick_i (
        .clk(clk), .rst(rst), .run(busy), .tick(tick)
    );

    ow_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst(rst), .d(bus_in), .q(line_s)
    );

    ow_slot_seq #(.BYTE_W(BYTE_W)) seq_i (
        .clk(clk), .rst(rst), .start(start), .op_code(op_code),
        .wr_byte(wr_byte), .tmg(tmg), .tick(tick), .line_s(line_s),
        .busy(busy), .done(done), .presence(presence), .rd_byte(rd_byte),
        .line_oe(bus_pull)
    );

    AST_SPEED_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(spd_q)); // R8
    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
        (!busy && !$past(busy)) |-> !bus_pull); // R11
endmodule

// File: tb/ow_master_tb.sv
module ow_master_tb_top;
    localparam int K = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [2:0] op_code = 3'd0;
    logic [7:0] wr_byte = 8'd0;
    logic       speed_od = 1'b0;
    logic       busy, done, presence, bus_pull, bus_in;
    logic [7:0] rd_byte;

    // device model
    logic       pres_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] pat = 8'd0;
    int         slot_i = 0;
    logic       cur_bit = 1'b1;

    int errors = 0;
    int checks = 0;
    int busy_cnt = 0, done_cnt = 0, oe_run = 0, nlow = 0;
    int lows [0:15];

    always #2 clk = ~clk;

    ow_master #(.CLKS_PER_US(K)) dut_i (
        .clk(clk), .rst(rst), .start(start), .op_code(op_code),
        .wr_byte(wr_byte), .speed_od(speed_od), .busy(busy), .done(done),
        .presence(presence), .rd_byte(rd_byte), .bus_pull(bus_pull),
        .bus_in(bus_in)
    );

    always @(posedge bus_pull) begin
        cur_bit = pat[slot_i % 8];
        slot_i  = slot_i + 1;
    end

    assign bus_in = ~(bus_pull | pres_en | (rd_en & ~cur_bit));

    always @(negedge clk) begin
        if (bus_pull) oe_run = oe_run + 1;
        else if (oe_run != 0) begin
            if (nlow < 16) lows[nlow] = oe_run;
            nlow   = nlow + 1;
            oe_run = 0;
        end
        if (busy) busy_cnt = busy_cnt + 1;
        if (done) done_cnt = done_cnt + 1;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        busy_cnt = 0; done_cnt = 0; nlow = 0; oe_run = 0;
    endtask

    task automatic launch(input logic [2:0] code, input logic [7:0] data);
        start = 1'b1; op_code = code; wr_byte = data;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic run_op(input logic [2:0] code, input logic [7:0] data);
        @(negedge clk);
        clear_mon();
        launch(code, data);
        wait_done();
    endtask

    task automatic t_reset_state();
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 bus_pull", bus_pull, 0);
        chk("R1 rd_byte", rd_byte, 0);
        chk("R1 presence", presence, 0);
    endtask

    task automatic t_bus_reset_std();
        pres_en = 1'b0;
        run_op(3'd0, 8'h00);
        chk("R2 no device presence", presence, 0);
        chk("R2 busy length", busy_cnt, 960 * K);
        chk("R2 low length", lows[0], 480 * K);
        chk("R10 done pulses", done_cnt, 1);
        // device pulls the line while released
        pres_en = 1'b1;
        run_op(3'd0, 8'h00);
        pres_en = 1'b0;
        chk("R2 device presence", presence, 1);
        chk("R11 one low pulse", nlow, 1);
    endtask

    task automatic t_write_bits();
        run_op(3'd1, 8'h01);
        chk("R3 write1 low", lows[0], 6 * K);
        chk("R3 write1 length", busy_cnt, 70 * K);
        run_op(3'd1, 8'hFE);
        chk("R3 write0 low", lows[0], 60 * K);
        chk("R3 write0 length", busy_cnt, 70 * K);
        chk("R10 presence kept", presence, 1);
    endtask

    task automatic t_read_bits();
        rd_en = 1'b1; slot_i = 0; pat = 8'h01;
        run_op(3'd2, 8'h00);
        chk("R4 read 1", rd_byte, 1);
        chk("R4 read low", lows[0], 6 * K);
        chk("R4 read length", busy_cnt, 70 * K);
        slot_i = 0; pat = 8'h00;
        run_op(3'd2, 8'h00);
        chk("R4 read 0", rd_byte, 0);
        rd_en = 1'b0;
    endtask

    task automatic t_write_byte();
        logic [7:0] got;
        run_op(3'd3, 8'hA5);
        got = 8'h00;
        for (int i = 0; i < 8; i++) got[i] = (lows[i] == 6 * K);
        chk("R5 byte bits lsb first", got, 8'hA5);
        chk("R5 slot count", nlow, 8);
        chk("R5 byte length", busy_cnt, 8 * 70 * K);
    endtask

    task automatic t_read_byte();
        rd_en = 1'b1; slot_i = 0; pat = 8'h3C;
        run_op(3'd4, 8'h00);
        chk("R6 byte read", rd_byte, 8'h3C);
        slot_i = 0; pat = 8'h81;
        run_op(3'd4, 8'h00);
        chk("R6 byte read ends", rd_byte, 8'h81);
        rd_en = 1'b0;
        pres_en = 1'b0;
        run_op(3'd0, 8'h00);
        chk("R10 rd_byte kept after reset", rd_byte, 8'h81);
    endtask

    task automatic t_overdrive();
        speed_od = 1'b1;
        run_op(3'd1, 8'h01);
        chk("R7 od write1 low", lows[0], 1 * K);
        chk("R7 od write1 length", busy_cnt, 8 * K);
        run_op(3'd1, 8'h00);
        chk("R7 od write0 low", lows[0], 7 * K);
        chk("R7 od write0 length", busy_cnt, 9 * K);
        run_op(3'd2, 8'h00);
        chk("R7 od read length", busy_cnt, 9 * K);
        pres_en = 1'b1;
        run_op(3'd0, 8'h00);
        pres_en = 1'b0;
        chk("R7 od reset length", busy_cnt, 120 * K);
        chk("R7 od reset low", lows[0], 70 * K);
        chk("R7 od presence", presence, 1);
        speed_od = 1'b0;
    endtask

    task automatic t_speed_busy();
        // change one clock after start: ignored
        @(negedge clk);
        clear_mon();
        launch(3'd1, 8'h00);
        speed_od = 1'b1;
        wait_done();
        chk("R8 low kept standard", lows[0], 60 * K);
        chk("R8 length kept standard", busy_cnt, 70 * K);
        // change in the same clock as start: applies
        speed_od = 1'b0;
        @(negedge clk);
        clear_mon();
        speed_od = 1'b1;
        launch(3'd1, 8'h01);
        wait_done();
        chk("R8 taken with start", busy_cnt, 8 * K);
        speed_od = 1'b0;
    endtask

    task automatic t_start_busy();
        @(negedge clk);
        clear_mon();
        launch(3'd1, 8'h01);
        repeat (50) @(negedge clk);
        launch(3'd0, 8'h00);
        wait_done();
        repeat (20) @(negedge clk);
        chk("R9 length unchanged", busy_cnt, 70 * K);
        chk("R9 single low pulse", nlow, 1);
        chk("R9 single done", done_cnt, 1);
    endtask

    task automatic t_back_to_back();
        @(negedge clk);
        clear_mon();
        launch(3'd1, 8'h01);
        while (!done) @(negedge clk);
        launch(3'd1, 8'h00);
        wait_done();
        chk("R10 back-to-back done count", done_cnt, 2);
        chk("R3 second slot low", lows[1], 60 * K);
        chk("R3 both slots length", busy_cnt, 140 * K);
    endtask

    task automatic t_bad_op();
        @(negedge clk);
        clear_mon();
        launch(3'd6, 8'hFF);
        repeat (10) @(negedge clk);
        chk("R12 no busy", busy_cnt, 0);
        chk("R12 no pull", nlow + oe_run, 0);
        chk("R11 idle released", bus_pull, 0);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(180000 * 4);
        errors = errors + 1;
        checks = checks + 1;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset_state();
        t_bus_reset_std();
        t_write_bits();
        t_read_bits();
        t_write_byte();
        t_read_byte();
        t_overdrive();
        t_speed_busy();
        t_start_busy();
        t_back_to_back();
        t_bad_op();
        finish_run();
    end
endmodule